// File: doc/BRIEF.md
# Interrupt Status and IRQ Release Controller

This block keeps a set of sticky interrupt flags, qualifies them with a mask register and drives an active-low interrupt request line toward a host processor. Event sources pulse one flag input for a single clock. The flag then stays set until the host reads it back through a clearing alias of the status register, or until a reset.

The serial slave interface in front of the block reports transaction progress with two strobes. The first marks the end of a command byte and carries the decoded address and direction. The second marks the moment the last data bit of the transfer has been shifted out. When the command is a read of the status register or of its clearing alias, the request line is released high. It stays high for the whole data phase, so that the host's interrupt service routine sees a clean edge. When the data phase ends, the line is evaluated again and drops low only if an unmasked flag is still pending.

A snapshot of the flags is taken when the read command completes, and it is presented as the status word for the shifter to send. A plain read leaves the flags alone. The clearing read removes exactly the flags it returned. Any event that arrives in the same cycle or later is kept.

Top module: `irq_status_ctrl`

## Requirements
- R1: With no status read in progress, `irq_n` is low one cycle after any flag is set whose mask bit is 1, and high when no flag has its mask bit set.
- R2: A `cmd_strobe` with `cmd_is_read`=1 and `cmd_addr` equal to STAT_ADDR (default 0x19) or RSTAT_ADDR (default 0x1A) drives `irq_n` high from the next cycle. `irq_n` stays high, whatever events arrive, until `xfer_end` pulses.
- R3: In the cycle after `xfer_end` ends a held read, `irq_n` is low if any unmasked flag is pending, and high otherwise.
- R4: A one-cycle pulse on bit i of `evt_i` sets flag i at the next clock edge. Only a clearing read or a reset clears a flag.
- R5: A clearing read (address RSTAT_ADDR) loads the current flags into `status_o` and clears those flags at the same edge.
- R6: An event that coincides with or follows the strobe of a clearing read stays set after the clear.
- R7: A plain read (address STAT_ADDR) loads the flags into `status_o` one cycle after the strobe and changes no flag.
- R8: `mask_we` loads `mask_wdata` into the mask. Masked flags are still recorded and reported in `status_o`, but they do not drive `irq_n`.
- R9: `rst_n` low (asynchronous) or `sw_rst` high (synchronous) clears every flag, the mask, the hold state and `status_o`, and sets `irq_n` high.
- R10: A command strobe that is a write, or that names any other address, does not release `irq_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous device reset, active low |
| sw_rst | input | 1 | Synchronous software reset |
| evt_i | input | NUM_FLAGS | Single-cycle interrupt event pulses |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | NUM_FLAGS | New mask value, 1 enables a flag |
| cmd_strobe | input | 1 | End of a command byte from the serial slave |
| cmd_is_read | input | 1 | Command direction, 1 means read |
| cmd_addr | input | ADDR_W | Register address carried by the command |
| xfer_end | input | 1 | Last data bit of the transfer has been shifted out |
| irq_n | output | 1 | Interrupt request, active low |
| status_o | output | NUM_FLAGS | Flag snapshot taken by the last status read |

## Verification
The bench builds the block with six flags, so every flag bit can be checked and the mask can split pending flags into enabled and disabled groups. It keeps the default status and clearing addresses, and it sends a third, unrelated address so that decode misses can be exercised. Directed sequences cover these cases: an event arriving while the line is held, a clearing read that coincides with a new event, and a software reset that falls between transfers. A random phase then interleaves events, mask writes and overlapping command and end strobes, and checks them against the cycle model.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

   typedef enum logic {
      REL_LIVE = 1'b0,
      REL_HELD = 1'b1
   } rel_state_e;

   function automatic logic addr_is(input logic [31:0] a, input logic [31:0] ref_addr);
      return a == ref_addr;
   endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int NUM_FLAGS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sw_rst,
   input  logic [NUM_FLAGS-1:0] evt_i,
   input  logic                 cap_i,
   input  logic                 clr_i,
   output logic [NUM_FLAGS-1:0] flags_o,
   output logic [NUM_FLAGS-1:0] flags_nxt_o,
   output logic [NUM_FLAGS-1:0] snap_o
);

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_bit
      logic flag_q, snap_q, flag_d;

      always_comb begin
         if (sw_rst) flag_d = 1'b0;
         else        flag_d = (flag_q & ~clr_i) | evt_i[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_q <= 1'b0;
            snap_q <= 1'b0;
         end else begin
            flag_q <= flag_d;
            if (sw_rst)     snap_q <= 1'b0;
            else if (cap_i) snap_q <= flag_q;
         end
      end

      assign flags_o[i]     = flag_q;
      assign flags_nxt_o[i] = flag_d;
      assign snap_o[i]      = snap_q;
   end

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !sw_rst) |=> (($past(flags_o) & ~flags_o) == '0)); // R4
   AST_EVT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_rst) |=> ((flags_o & $past(evt_i)) == $past(evt_i))); // R6
   AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !sw_rst) |=> ((flags_o & ~$past(evt_i)) == '0)); // R5

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int NUM_FLAGS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sw_rst,
   input  logic                 we_i,
   input  logic [NUM_FLAGS-1:0] wdata_i,
   output logic [NUM_FLAGS-1:0] mask_nxt_o
);

   logic [NUM_FLAGS-1:0] mask_q;

   always_comb begin
      if (sw_rst)    mask_nxt_o = '0;
      else if (we_i) mask_nxt_o = wdata_i;
      else           mask_nxt_o = mask_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= mask_nxt_o;
   end

   AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && !sw_rst) |=> (mask_q == $past(wdata_i))); // R8

endmodule

// File: rtl/irq_release_ctrl.sv
module irq_release_ctrl
   import irq_status_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sw_rst,
   input  logic start_rd_i,
   input  logic xfer_end_i,
   input  logic pend_nxt_i,
   output logic irq_n_o
);

   rel_state_e state_q, state_d;
   logic       irq_n_d;

   always_comb begin
      if (sw_rst)          state_d = REL_LIVE;
      else if (start_rd_i) state_d = REL_HELD;
      else if (xfer_end_i) state_d = REL_LIVE;
      else                 state_d = state_q;
      irq_n_d = sw_rst | (state_d == REL_HELD) | ~pend_nxt_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= REL_LIVE;
         irq_n_o <= 1'b1;
      end else begin
         state_q <= state_d;
         irq_n_o <= irq_n_d;
      end
   end

   AST_RELEASE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      start_rd_i |=> irq_n_o); // R2
   AST_HOLD_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == REL_HELD && !xfer_end_i) |=> irq_n_o); // R2
   AST_REEVAL_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == REL_HELD && xfer_end_i && !start_rd_i && !sw_rst)
      |=> (irq_n_o != $past(pend_nxt_i))); // R3

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
   import irq_status_pkg::*;
#(
   parameter int          NUM_FLAGS  = 8,
   parameter int          ADDR_W     = 7,
   parameter logic [31:0] STAT_ADDR  = 32'h19,
   parameter logic [31:0] RSTAT_ADDR = 32'h1A
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sw_rst,
   input  logic [NUM_FLAGS-1:0] evt_i,
   input  logic                 mask_we,
   input  logic [NUM_FLAGS-1:0] mask_wdata,
   input  logic                 cmd_strobe,
   input  logic                 cmd_is_read,
   input  logic [ADDR_W-1:0]    cmd_addr,
   input  logic                 xfer_end,
   output logic                 irq_n,
   output logic [NUM_FLAGS-1:0] status_o
);

   localparam int ADDR_SPAN = 1 << ADDR_W;

   if (NUM_FLAGS < 1 || NUM_FLAGS > 32) begin : g_bad_width
      $error("NUM_FLAGS must lie in 1..32");
   end
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr_w
      $error("ADDR_W must lie in 1..16");
   end
   if (STAT_ADDR >= ADDR_SPAN || RSTAT_ADDR >= ADDR_SPAN || STAT_ADDR == RSTAT_ADDR) begin : g_bad_map
      $error("status addresses must be distinct and fit ADDR_W");
   end

   logic [31:0]          addr_ext;
   logic                 hit_plain, hit_clr, start_rd, start_clr, pend_nxt;
   logic [NUM_FLAGS-1:0] flags, flags_nxt, mask_nxt;

   assign addr_ext  = {{(32-ADDR_W){1'b0}}, cmd_addr};
   assign hit_plain = addr_is(addr_ext, STAT_ADDR);
   assign hit_clr   = addr_is(addr_ext, RSTAT_ADDR);
   assign start_rd  = cmd_strobe & cmd_is_read & (hit_plain | hit_clr);
   assign start_clr = cmd_strobe & cmd_is_read & hit_clr;
   assign pend_nxt  = |(flags_nxt & mask_nxt);

   irq_flag_bank #(.NUM_FLAGS(NUM_FLAGS)) u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .sw_rst      (sw_rst),
      .evt_i       (evt_i),
      .cap_i       (start_rd),
      .clr_i       (start_clr),
      .flags_o     (flags),
      .flags_nxt_o (flags_nxt),
      .snap_o      (status_o)
   );

   irq_mask_reg #(.NUM_FLAGS(NUM_FLAGS)) u_mask (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_rst     (sw_rst),
      .we_i       (mask_we),
      .wdata_i    (mask_wdata),
      .mask_nxt_o (mask_nxt)
   );

   irq_release_ctrl u_rel (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_rst     (sw_rst),
      .start_rd_i (start_rd),
      .xfer_end_i (xfer_end),
      .pend_nxt_i (pend_nxt),
      .irq_n_o    (irq_n)
   );

   AST_SWRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rst |=> (irq_n && status_o == '0 && flags == '0)); // R9
   AST_OTHER_CMD_NO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_strobe && !start_rd && !sw_rst && !xfer_end && irq_n == 1'b0 && evt_i == '0 && !mask_we)
      |=> !irq_n); // R10

endmodule

// File: tb/irq_status_ctrl_test.sv
`timescale 1ns/1ps
module irq_status_ctrl_test;

   localparam int N     = 6;
   localparam int AW    = 7;
   localparam int STAT  = 'h19;
   localparam int RSTAT = 'h1A;
   localparam int OTHER = 'h05;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sw_rst = 1'b0;
   logic [N-1:0]  evt_i = '0;
   logic          mask_we = 1'b0;
   logic [N-1:0]  mask_wdata = '0;
   logic          cmd_strobe = 1'b0;
   logic          cmd_is_read = 1'b0;
   logic [AW-1:0] cmd_addr = '0;
   logic          xfer_end = 1'b0;
   logic          irq_n;
   logic [N-1:0]  status_o;

   int    vectors = 0;
   int    fails = 0;
   string cur_req = "R9";

   always #4 clk = ~clk;

   irq_status_ctrl #(.NUM_FLAGS(N), .ADDR_W(AW), .STAT_ADDR(STAT), .RSTAT_ADDR(RSTAT)) uut (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .evt_i(evt_i),
      .mask_we(mask_we), .mask_wdata(mask_wdata), .cmd_strobe(cmd_strobe),
      .cmd_is_read(cmd_is_read), .cmd_addr(cmd_addr), .xfer_end(xfer_end),
      .irq_n(irq_n), .status_o(status_o)
   );

   // behavioural reference
   logic [N-1:0] m_flags, m_mask, m_snap;
   bit           m_hold, m_irq;
   always @(posedge clk) begin
      bit rd, clr;
      if (!rst_n || sw_rst) begin
         m_flags = '0; m_mask = '0; m_snap = '0; m_hold = 0; m_irq = 1;
      end else begin
         rd  = cmd_strobe && cmd_is_read && (cmd_addr == STAT || cmd_addr == RSTAT);
         clr = rd && (cmd_addr == RSTAT);
         if (rd) m_snap = m_flags;
         m_flags = (clr ? '0 : m_flags) | evt_i;
         if (mask_we) m_mask = mask_wdata;
         if (rd) m_hold = 1;
         else if (xfer_end) m_hold = 0;
         m_irq = m_hold || ((m_flags & m_mask) == '0);
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         vectors++;
         if (irq_n !== m_irq || status_o !== m_snap) begin
            fails++;
            $display("FAIL %s model: irq_n=%0b status=%0h expected irq_n=%0b status=%0h",
                     cur_req, irq_n, status_o, m_irq, m_snap);
         end
      end
   end

   task automatic chk(input string tag, input int got, input int exp);
      vectors++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #2;
      evt_i = '0; mask_we = 0; cmd_strobe = 0; cmd_is_read = 0; xfer_end = 0; sw_rst = 0;
   endtask

   task automatic look();
      @(negedge clk);
   endtask

   task automatic cmd(input int addr, input bit rd, input logic [N-1:0] ev);
      cmd_strobe = 1; cmd_is_read = rd; cmd_addr = AW'(addr); evt_i = ev;
      tick();
   endtask

   task automatic wr_mask(input logic [N-1:0] m);
      mask_we = 1; mask_wdata = m; tick();
   endtask

   task automatic finish_rd();
      xfer_end = 1; tick();
   endtask

   initial begin
      #(8 * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      look();
      chk("R9 reset irq", irq_n, 1);
      chk("R9 reset status", status_o, 0);

      cur_req = "R8";
      evt_i = 6'b000100; tick(); look();
      chk("R8 masked flag no irq", irq_n, 1);

      cur_req = "R7";
      cmd(STAT, 1, '0); look();
      chk("R7 plain read status", status_o, 6'b000100);
      chk("R2 held after read cmd", irq_n, 1);
      finish_rd(); look();
      chk("R3 masked pending stays high", irq_n, 1);

      cur_req = "R1";
      wr_mask(6'b000110); look();
      chk("R1 unmasked pending irq low", irq_n, 0);

      cur_req = "R2";
      cmd(STAT, 1, '0);
      tick(); tick(); look();
      chk("R2 still held mid data", irq_n, 1);
      chk("R7 status unchanged value", status_o, 6'b000100);
      finish_rd(); look();
      chk("R3 re-assert after read", irq_n, 0);

      cur_req = "R6";
      cmd(RSTAT, 1, 6'b000010); look();
      chk("R5 clearing read returns flags", status_o, 6'b000100);
      finish_rd(); look();
      chk("R6 coincident event keeps irq", irq_n, 0);
      cmd(STAT, 1, '0); finish_rd(); look();
      chk("R5 R6 flags after clear", status_o, 6'b000010);

      cur_req = "R5";
      cmd(RSTAT, 1, '0); tick(); finish_rd(); look();
      chk("R3 nothing pending stays high", irq_n, 1);
      cmd(STAT, 1, '0); finish_rd(); look();
      chk("R5 all returned flags cleared", status_o, 0);

      cur_req = "R10";
      evt_i = 6'b000100; tick(); look();
      chk("R1 event asserts irq", irq_n, 0);
      cmd(STAT, 0, '0); look();
      chk("R10 write cmd keeps irq", irq_n, 0);
      cmd(OTHER, 1, '0); look();
      chk("R10 other address keeps irq", irq_n, 0);

      cur_req = "R2";
      cmd(RSTAT, 1, '0); tick();
      evt_i = 6'b000010; tick(); look();
      chk("R2 event during hold stays high", irq_n, 1);
      finish_rd(); look();
      chk("R3 event during hold reasserts", irq_n, 0);

      cur_req = "R9";
      sw_rst = 1; tick(); look();
      chk("R9 sw reset irq high", irq_n, 1);
      chk("R9 sw reset status", status_o, 0);
      evt_i = 6'b000110; tick(); look();
      chk("R9 mask cleared by sw reset", irq_n, 1);
      cmd(STAT, 1, '0); finish_rd(); look();
      chk("R4 flags set after reset", status_o, 6'b000110);

      cur_req = "R1 R4 random";
      begin
         int cnt = 0;
         for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(0, 5) == 0) evt_i = N'($urandom);
            if ($urandom_range(0, 20) == 0) begin mask_we = 1; mask_wdata = N'($urandom); end
            if (cnt == 0 && $urandom_range(0, 6) == 0) begin
               int pick = $urandom_range(0, 2);
               cmd_strobe = 1; cmd_is_read = ($urandom_range(0, 3) != 0);
               cmd_addr = AW'(pick == 0 ? STAT : (pick == 1 ? RSTAT : OTHER));
               cnt = $urandom_range(1, 9);
            end else if (cnt > 0) begin
               cnt--;
               if (cnt == 0) xfer_end = 1;
            end
            if ($urandom_range(0, 400) == 0) sw_rst = 1;
            tick();
         end
      end

      look();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule